// File: doc/BRIEF.md
# Node Message Port

This block sits between one processing node and an interleaving network. On the send side, the processor issues a store through a single-cycle port mapped into its address space. The store has a 16-bit address and 16-bit data. The block packs the store into a 30-bit network message and holds it in an output register until the network takes it. On the receive side, messages from the network enter a small FIFO. The FIFO drains one message per cycle into one of two local buffers, so a receiver can fill one buffer while the processor reads the other. A pair of saturating counters reports how many messages have been written into each buffer since the last clear.

Every data path is valid/ready. A transfer happens on a rising edge where both valid and ready are high.

- **Processor side.** The processor holds `cpu_wr_valid` and its address and data steady while `cpu_wr_ready` is low.
- **Network output.** The network may hold `tx_ready` low for any length of time. The block holds `tx_valid` and `tx_msg` steady during that time.
- **Network input.** A message offered on `rx_valid` while `rx_ready` is low is not taken.
- **Local write port.** The buffer side grants the port with `buf_wr_ready`. While that grant is low, no strobe is issued and the FIFO keeps its head.

Message layout, from the most significant bit:

| Bits | Field |
|------|-------|
| [29:23] | Target processor |
| [22] | Buffer select |
| [21:8] | Local address |
| [7:0] | Data |

Top module: `node_msg_port`

## Requirements
- R1: After reset, `tx_valid` is 0, `rx_ready` is 1, `buf0_we` and `buf1_we` are 0, and both counts are 0.
- R2: A store accepted on a rising edge produces, from that edge on, `tx_valid`=1 with `tx_msg` laid out as follows:
  - `tx_msg[29:23]` = `cpu_wr_data[14:8]` (target);
  - `tx_msg[22]` = `cpu_wr_addr[14]` (buffer select);
  - `tx_msg[21:8]` = `cpu_wr_addr[13:0]` (local address);
  - `tx_msg[7:0]` = `cpu_wr_data[7:0]` (data).

  Bit 15 of the address and bit 15 of the data have no effect.
- R3: While `tx_valid` is 1 and `tx_ready` is 0, `tx_msg` stays unchanged and `cpu_wr_ready` is 0. A store held pending in that time is sent after the current message, with no loss.
- R4: While `tx_ready` is 1, `cpu_wr_ready` is 1, so one store per cycle is packed and sent back to back.
- R5: A received message is presented on the local port from the cycle after it is taken, as follows:
  - `buf_wr_addr` = `msg[21:8]` and `buf_wr_data` = `msg[7:0]`;
  - `buf0_we` rises when `msg[22]`=0, and `buf1_we` rises when `msg[22]`=1, while `buf_wr_ready` is 1;
  - at most one strobe is high at a time, and the target field is ignored.
- R6: Received messages are written locally in arrival order, at one message per cycle.
- R7: With FIFO_DEPTH messages stored, `rx_ready` is 0, and a message offered then is not stored.
- R8: While `buf_wr_ready` is 0, no strobe is issued and the stored messages are kept.
- R9: Each count increments by one for each strobe of its own buffer and saturates at 2^CNT_W-1.
- R10: When `cnt_clr` is 1 on an edge, both counts read 0 after that edge, and a strobe in the same cycle is not counted.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Active-low synchronous reset |
| cpu_wr_valid | input | 1 | Processor store request |
| cpu_wr_ready | output | 1 | Store accepted on this edge when high with valid |
| cpu_wr_addr | input | 16 | Store address |
| cpu_wr_data | input | 16 | Store data |
| tx_valid | output | 1 | Outbound message valid |
| tx_ready | input | 1 | Network accepts outbound message |
| tx_msg | output | 30 | Outbound message |
| rx_valid | input | 1 | Inbound message valid |
| rx_ready | output | 1 | Inbound FIFO has room |
| rx_msg | input | 30 | Inbound message |
| buf_wr_ready | input | 1 | Local write port granted |
| buf0_we | output | 1 | Write strobe, buffer 0 |
| buf1_we | output | 1 | Write strobe, buffer 1 |
| buf_wr_addr | output | 14 | Local write address |
| buf_wr_data | output | 8 | Local write data |
| cnt_clr | input | 1 | Clear both counts |
| buf0_count | output | CNT_W | Messages written to buffer 0 |
| buf1_count | output | CNT_W | Messages written to buffer 1 |

## Verification
The bench builds the block with FIFO_DEPTH=4 and CNT_W=3.

- With a depth of 4, four held messages fill the FIFO. This makes the full condition, the refused fifth message and the in-order drain easy to reach.
- With a 3-bit count, the counter saturates at 7 within nine writes. This brings the saturation limit within reach, along with a clear that lands in the same cycle as a write.

// File: rtl/nmp_pkg.sv
package nmp_pkg;
  localparam int CPU_W   = 16;
  localparam int TGT_W   = 7;
  localparam int LADDR_W = 14;
  localparam int PAY_W   = 8;
  localparam int MSG_W   = TGT_W + 1 + LADDR_W + PAY_W;

  // Field order from MSB: target, buffer select, local address, data
  typedef struct packed {
    logic [TGT_W-1:0]   tgt;
    logic               bsel;
    logic [LADDR_W-1:0] laddr;
    logic [PAY_W-1:0]   pay;
  } msg_t;

  function automatic msg_t pack_store(input logic [CPU_W-1:0] addr,
                                      input logic [CPU_W-1:0] data);
    msg_t m;
    m.tgt   = data[PAY_W +: TGT_W];
    m.bsel  = addr[LADDR_W];
    m.laddr = addr[LADDR_W-1:0];
    m.pay   = data[PAY_W-1:0];
    return m;
  endfunction
endpackage

// File: rtl/nmp_pack.sv
module nmp_pack
  import nmp_pkg::*;
(
  input  logic             clk,
  input  logic             rst_n,
  input  logic             st_valid,
  output logic             st_ready,
  input  logic [CPU_W-1:0] st_addr,
  input  logic [CPU_W-1:0] st_data,
  output logic             tx_valid,
  input  logic             tx_ready,
  output msg_t             tx_msg
);
  logic tx_valid_q;
  msg_t tx_msg_q;
  logic unused_bits;

  assign unused_bits = ^{st_addr[CPU_W-1], st_data[CPU_W-1]};
  assign st_ready    = !tx_valid_q || tx_ready;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      tx_valid_q <= 1'b0;
      tx_msg_q   <= '0;
    end else if (st_ready) begin
      tx_valid_q <= st_valid;
      if (st_valid) tx_msg_q <= pack_store(st_addr, st_data);
    end
  end

  assign tx_valid = tx_valid_q;
  assign tx_msg   = tx_msg_q;

  // R3
  tx_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (tx_valid && !tx_ready) |=> (tx_valid && $stable(tx_msg)));
endmodule

// File: rtl/nmp_fifo.sv
module nmp_fifo #(
  parameter int W     = 30,
  parameter int DEPTH = 8
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic         in_valid,
  output logic         in_ready,
  input  logic [W-1:0] in_data,
  output logic         out_valid,
  input  logic         out_ready,
  output logic [W-1:0] out_data
);
  localparam int PW = (DEPTH > 1) ? $clog2(DEPTH) : 1;
  localparam int CW = $clog2(DEPTH + 1);
  localparam logic [PW-1:0] LAST = PW'(DEPTH - 1);
  localparam logic [CW-1:0] FULL = CW'(DEPTH);

  logic [W-1:0]  mem [DEPTH];
  logic [PW-1:0] wr_ptr, rd_ptr;
  logic [CW-1:0] count;
  logic          push, pop;

  assign in_ready  = (count != FULL);
  assign out_valid = (count != '0);
  assign push      = in_valid && in_ready;
  assign pop       = out_valid && out_ready;
  assign out_data  = mem[rd_ptr];

  always_ff @(posedge clk) begin
    if (push) mem[wr_ptr] <= in_data;
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      wr_ptr <= '0;
      rd_ptr <= '0;
      count  <= '0;
    end else begin
      if (push) wr_ptr <= (wr_ptr == LAST) ? '0 : wr_ptr + 1'b1;
      if (pop)  rd_ptr <= (rd_ptr == LAST) ? '0 : rd_ptr + 1'b1;
      if (push && !pop)      count <= count + 1'b1;
      else if (pop && !push) count <= count - 1'b1;
    end
  end

  // R7
  no_overflow_chk: assert property (@(posedge clk) disable iff (!rst_n)
    count <= FULL);

  // R6
  fifo_count_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (in_valid && in_ready && !(out_valid && out_ready)) |=> (count == $past(count) + 1'b1));
endmodule

// File: rtl/nmp_unpack.sv
module nmp_unpack
  import nmp_pkg::*;
#(
  parameter int CNT_W = 16
) (
  input  logic               clk,
  input  logic               rst_n,
  input  logic               in_valid,
  output logic               in_ready,
  input  msg_t               in_msg,
  input  logic               mem_ready,
  output logic [1:0]         we,
  output logic [LADDR_W-1:0] waddr,
  output logic [PAY_W-1:0]   wdata,
  input  logic               cnt_clr,
  output logic [CNT_W-1:0]   cnt0,
  output logic [CNT_W-1:0]   cnt1
);
  localparam logic [CNT_W-1:0] CMAX = '1;

  logic             fire;
  logic [CNT_W-1:0] cnt_q [2];
  logic             unused_tgt;

  assign unused_tgt = ^in_msg.tgt;
  assign in_ready   = mem_ready;
  assign fire       = in_valid && mem_ready;
  assign waddr      = in_msg.laddr;
  assign wdata      = in_msg.pay;

  for (genvar g = 0; g < 2; g++) begin : g_buf
    assign we[g] = fire && (in_msg.bsel == 1'(g));

    always_ff @(posedge clk) begin
      if (!rst_n || cnt_clr)           cnt_q[g] <= '0;
      else if (we[g] && cnt_q[g] != CMAX) cnt_q[g] <= cnt_q[g] + 1'b1;
    end

    // R10
    cnt_clear_chk: assert property (@(posedge clk) disable iff (!rst_n)
      cnt_clr |=> (cnt_q[g] == '0));

    // R9
    cnt_sat_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (cnt_q[g] == CMAX && !cnt_clr) |=> (cnt_q[g] == CMAX));
  end

  assign cnt0 = cnt_q[0];
  assign cnt1 = cnt_q[1];

  // R5
  wr_onehot_chk: assert property (@(posedge clk) disable iff (!rst_n)
    $onehot0(we));
endmodule

// File: rtl/node_msg_port.sv
module node_msg_port
  import nmp_pkg::*;
#(
  parameter int FIFO_DEPTH = 8,
  parameter int CNT_W      = 16
) (
  input  logic               clk,
  input  logic               rst_n,
  input  logic               cpu_wr_valid,
  output logic               cpu_wr_ready,
  input  logic [15:0]        cpu_wr_addr,
  input  logic [15:0]        cpu_wr_data,
  output logic               tx_valid,
  input  logic               tx_ready,
  output logic [29:0]        tx_msg,
  input  logic               rx_valid,
  output logic               rx_ready,
  input  logic [29:0]        rx_msg,
  input  logic               buf_wr_ready,
  output logic               buf0_we,
  output logic               buf1_we,
  output logic [13:0]        buf_wr_addr,
  output logic [7:0]         buf_wr_data,
  input  logic               cnt_clr,
  output logic [CNT_W-1:0]   buf0_count,
  output logic [CNT_W-1:0]   buf1_count
);
  msg_t             tx_m;
  logic             head_valid, head_ready;
  logic [MSG_W-1:0] head_bits;
  logic [1:0]       we;

  nmp_pack u_pack (
    .clk      (clk),
    .rst_n    (rst_n),
    .st_valid (cpu_wr_valid),
    .st_ready (cpu_wr_ready),
    .st_addr  (cpu_wr_addr),
    .st_data  (cpu_wr_data),
    .tx_valid (tx_valid),
    .tx_ready (tx_ready),
    .tx_msg   (tx_m)
  );
  assign tx_msg = tx_m;

  nmp_fifo #(.W(MSG_W), .DEPTH(FIFO_DEPTH)) u_fifo (
    .clk       (clk),
    .rst_n     (rst_n),
    .in_valid  (rx_valid),
    .in_ready  (rx_ready),
    .in_data   (rx_msg),
    .out_valid (head_valid),
    .out_ready (head_ready),
    .out_data  (head_bits)
  );

  nmp_unpack #(.CNT_W(CNT_W)) u_unpack (
    .clk       (clk),
    .rst_n     (rst_n),
    .in_valid  (head_valid),
    .in_ready  (head_ready),
    .in_msg    (msg_t'(head_bits)),
    .mem_ready (buf_wr_ready),
    .we        (we),
    .waddr     (buf_wr_addr),
    .wdata     (buf_wr_data),
    .cnt_clr   (cnt_clr),
    .cnt0      (buf0_count),
    .cnt1      (buf1_count)
  );

  assign buf0_we = we[0];
  assign buf1_we = we[1];

  // R8
  no_grant_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !buf_wr_ready |-> !(buf0_we || buf1_we));
endmodule

// File: tb/test_node_msg_port.sv
module test_node_msg_port;
  localparam int DEPTH = 4;
  localparam int CW    = 3;

  logic clk = 0, rst_n = 0;
  logic cpu_wr_valid = 0, tx_ready = 0, rx_valid = 0, buf_wr_ready = 0, cnt_clr = 0;
  logic [15:0] cpu_wr_addr = 0, cpu_wr_data = 0;
  logic [29:0] rx_msg = 0;
  logic cpu_wr_ready, tx_valid, rx_ready, buf0_we, buf1_we;
  logic [29:0] tx_msg;
  logic [13:0] buf_wr_addr;
  logic [7:0]  buf_wr_data;
  logic [CW-1:0] buf0_count, buf1_count;

  int n_chk = 0, n_err = 0;
  bit done = 0;

  always #10 clk = ~clk;

  node_msg_port #(.FIFO_DEPTH(DEPTH), .CNT_W(CW)) i_node_msg_port (
    .clk(clk), .rst_n(rst_n),
    .cpu_wr_valid(cpu_wr_valid), .cpu_wr_ready(cpu_wr_ready),
    .cpu_wr_addr(cpu_wr_addr), .cpu_wr_data(cpu_wr_data),
    .tx_valid(tx_valid), .tx_ready(tx_ready), .tx_msg(tx_msg),
    .rx_valid(rx_valid), .rx_ready(rx_ready), .rx_msg(rx_msg),
    .buf_wr_ready(buf_wr_ready), .buf0_we(buf0_we), .buf1_we(buf1_we),
    .buf_wr_addr(buf_wr_addr), .buf_wr_data(buf_wr_data),
    .cnt_clr(cnt_clr), .buf0_count(buf0_count), .buf1_count(buf1_count)
  );

  task automatic chk(input string req, input string what,
                     input logic [31:0] act, input logic [31:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_err++;
      $display("FAIL %s %s: actual %0h expected %0h", req, what, act, exp);
    end
  endtask

  function automatic logic [29:0] exp_pack(input logic [15:0] a, input logic [15:0] d);
    return {d[14:8], a[14], a[13:0], d[7:0]};
  endfunction

  function automatic logic [29:0] mk(input logic [6:0] t, input logic b,
                                     input logic [13:0] la, input logic [7:0] p);
    return {t, b, la, p};
  endfunction

  task automatic step();
    @(negedge clk);
  endtask

  task automatic t_reset();
    rst_n = 0;
    repeat (3) step();
    rst_n = 1;
    #1;
    chk("R1", "tx_valid", 32'(tx_valid), 0);
    chk("R1", "rx_ready", 32'(rx_ready), 1);
    chk("R1", "strobes", 32'({buf1_we, buf0_we}), 0);
    chk("R1", "counts", 32'({buf1_count, buf0_count}), 0);
  endtask

  task automatic t_pack();
    step();
    tx_ready = 1; cpu_wr_valid = 1;
    cpu_wr_addr = 16'hC123; cpu_wr_data = 16'hD5A7;
    #1 chk("R4", "cpu_wr_ready idle", 32'(cpu_wr_ready), 1);
    step();
    cpu_wr_valid = 0;
    #1;
    chk("R2", "tx_valid", 32'(tx_valid), 1);
    chk("R2", "tx_msg", 32'(tx_msg), 32'(exp_pack(16'hC123, 16'hD5A7)));
    step();
    #1 chk("R2", "tx_valid drop", 32'(tx_valid), 0);
    // address and data bit 15 ignored
    cpu_wr_valid = 1; cpu_wr_addr = 16'h3FFF; cpu_wr_data = 16'h7F00;
    step();
    cpu_wr_valid = 0;
    #1 chk("R2", "bit15 ignored", 32'(tx_msg), 32'(exp_pack(16'hBFFF, 16'hFF00)));
    step();
  endtask

  task automatic t_stall();
    tx_ready = 0;
    cpu_wr_valid = 1; cpu_wr_addr = 16'h0011; cpu_wr_data = 16'h0A22;
    step();
    cpu_wr_addr = 16'h4033; cpu_wr_data = 16'h0B44;
    #1;
    chk("R3", "first held", 32'(tx_msg), 32'(exp_pack(16'h0011, 16'h0A22)));
    chk("R3", "cpu stalled", 32'(cpu_wr_ready), 0);
    step();
    #1;
    chk("R3", "still held", 32'(tx_msg), 32'(exp_pack(16'h0011, 16'h0A22)));
    chk("R3", "still stalled", 32'(cpu_wr_ready), 0);
    tx_ready = 1;
    #1 chk("R3", "ready follows tx", 32'(cpu_wr_ready), 1);
    step();
    cpu_wr_valid = 0;
    #1;
    chk("R3", "second sent", 32'(tx_msg), 32'(exp_pack(16'h4033, 16'h0B44)));
    chk("R3", "second valid", 32'(tx_valid), 1);
    step();
    #1 chk("R3", "drained", 32'(tx_valid), 0);
  endtask

  task automatic t_throughput();
    tx_ready = 1;
    for (int i = 0; i < 3; i++) begin
      cpu_wr_valid = 1;
      cpu_wr_addr = 16'(i * 16'h0101);
      cpu_wr_data = 16'(16'h0010 + i);
      #1 chk("R4", "ready each cycle", 32'(cpu_wr_ready), 1);
      if (i > 0)
        chk("R4", "back to back", 32'(tx_msg),
            32'(exp_pack(16'((i - 1) * 16'h0101), 16'(16'h0010 + i - 1))));
      step();
    end
    cpu_wr_valid = 0;
    #1 chk("R4", "last", 32'(tx_msg), 32'(exp_pack(16'h0202, 16'h0012)));
    step();
  endtask

  task automatic t_rx_basic();
    buf_wr_ready = 1;
    rx_valid = 1; rx_msg = mk(7'h55, 1'b1, 14'h2ABC, 8'h3C);
    step();
    rx_valid = 0;
    #1;
    chk("R5", "buf1_we", 32'(buf1_we), 1);
    chk("R5", "buf0_we", 32'(buf0_we), 0);
    chk("R5", "addr", 32'(buf_wr_addr), 32'h2ABC);
    chk("R5", "data", 32'(buf_wr_data), 32'h3C);
    step();
    #1;
    chk("R5", "single strobe", 32'({buf1_we, buf0_we}), 0);
    chk("R9", "count1", 32'(buf1_count), 1);
    chk("R9", "count0", 32'(buf0_count), 0);
  endtask

  task automatic t_fill();
    logic [29:0] m [4];
    m[0] = mk(7'h01, 1'b0, 14'h0005, 8'hA0);
    m[1] = mk(7'h02, 1'b1, 14'h1006, 8'hA1);
    m[2] = mk(7'h03, 1'b1, 14'h2007, 8'hA2);
    m[3] = mk(7'h04, 1'b0, 14'h3008, 8'hA3);
    buf_wr_ready = 0;
    for (int i = 0; i < 4; i++) begin
      rx_valid = 1; rx_msg = m[i];
      #1 chk("R7", "room", 32'(rx_ready), 1);
      step();
    end
    rx_msg = mk(7'h7F, 1'b0, 14'h3FFF, 8'hEE);
    #1;
    chk("R7", "full", 32'(rx_ready), 0);
    chk("R8", "no strobe", 32'({buf1_we, buf0_we}), 0);
    step();
    rx_valid = 0; buf_wr_ready = 1;
    for (int i = 0; i < 4; i++) begin
      #1;
      chk("R6", "order addr", 32'(buf_wr_addr), 32'(m[i][21:8]));
      chk("R6", "order data", 32'(buf_wr_data), 32'(m[i][7:0]));
      chk("R5", "strobe sel", 32'({buf1_we, buf0_we}), m[i][22] ? 32'd2 : 32'd1);
      step();
    end
    #1;
    chk("R7", "extra not stored", 32'({buf1_we, buf0_we}), 0);
    chk("R9", "count0", 32'(buf0_count), 2);
    chk("R9", "count1", 32'(buf1_count), 3);
  endtask

  task automatic t_saturate();
    cnt_clr = 1;
    step();
    cnt_clr = 0;
    #1 chk("R10", "clear", 32'({buf1_count, buf0_count}), 0);
    buf_wr_ready = 1;
    for (int i = 0; i < 9; i++) begin
      rx_valid = 1; rx_msg = mk(7'h10, 1'b0, 14'(i), 8'(i));
      step();
    end
    rx_valid = 0;
    step();
    step();
    #1;
    chk("R9", "saturate", 32'(buf0_count), 7);
    chk("R9", "other buffer", 32'(buf1_count), 0);
  endtask

  task automatic t_clear_race();
    buf_wr_ready = 0;
    rx_valid = 1; rx_msg = mk(7'h20, 1'b1, 14'h0100, 8'h77);
    step();
    rx_valid = 0; buf_wr_ready = 1; cnt_clr = 1;
    #1 chk("R10", "strobe in clear cycle", 32'(buf1_we), 1);
    step();
    cnt_clr = 0;
    #1;
    chk("R10", "count1 after race", 32'(buf1_count), 0);
    chk("R10", "count0 after race", 32'(buf0_count), 0);
  endtask

  initial begin
    t_reset();
    t_pack();
    t_stall();
    t_throughput();
    t_rx_basic();
    t_fill();
    t_saturate();
    t_clear_race();
    step();
    if (!done) begin
      done = 1;
      $display("Simulation finished: %0d checks, %0d errors", n_chk, n_err);
      $finish;
    end
  end

  initial begin
    repeat (20000) @(posedge clk);
    if (!done) begin
      done = 1;
      n_chk++; n_err++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("Simulation finished: %0d checks, %0d errors", n_chk, n_err);
      $finish;
    end
  end
endmodule